// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches host writes that land in the boot-RAM address window of a flash device and turns them into actions. Three command values are recognised: a warm-reset request, an identification request that places three identity bytes into the first three words of boot RAM, and a two-step load command. The load command is armed by one window write and fires on the next window write, but only when that second write carries all-zero data.

When a load fires, the block forms a sector number from the current block and page start addresses. The top bit of the block address selects whether a density mask is merged into the block field. The block pulses a load request carrying that sector number. In the same cycle it hands back a new page start address, advanced by one page.

Window decoding is done upstream and reaches this block as a single hit flag. The flag covers both boot command ranges: the low 512-word area and the 16-word area that starts at 0x8000. The page transfer itself, the boot RAM and the address registers live outside the block.

Top module: `boot_cmd_seq`

## Requirements
- R1: While reset is applied, and until the first window write after its release, rst_req, load_req, page_upd_we and id_we are all low.
- R2: When no load is armed, a window write of 0x00F0 gives a single-cycle rst_req pulse on the following cycle.
- R3: When no load is armed, a window write of 0x00E0 arms a load and drives no output.
- R4: While a load is armed, a window write of 0x0000 disarms it and pulses load_req for one cycle on the following cycle. With that pulse, load_sector[7:0] equals page_addr[7:0] and load_sector[19:8] equals the block field.
- R5: In the same cycle as load_req, page_upd_we is high and page_upd_data is {8'h00, page_addr[7:0] + 4 modulo 256}.
- R6: While a load is armed, a window write of any non-zero value disarms it, drives no output, and is not decoded as a command.
- R7: When no load is armed, a window write of 0x0090 gives a one-cycle id_we pulse on the following cycle, with id_byte0 = mfr_id[7:0], id_byte1 = dev_id[7:0] and id_byte2 = prot_stat[7:0].
- R8: When no load is armed, any other window value is ignored. A write with win_hit or wr_en low is ignored whatever its data, and an armed load stays armed across it.
- R9: The block field is blk_addr[11:0] when blk_addr[15] is 0, and blk_addr[11:0] OR DENSITY_MASK when blk_addr[15] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| win_hit | input | 1 | Write address is inside a boot command range |
| wr_data | input | 16 | Host write data |
| blk_addr | input | 16 | Block start address register |
| page_addr | input | 16 | Page start address register |
| mfr_id | input | 16 | Manufacturer identity |
| dev_id | input | 16 | Device identity |
| prot_stat | input | 16 | Write-protection status |
| rst_req | output | 1 | Warm-reset request pulse |
| load_req | output | 1 | One-page load request pulse |
| load_sector | output | 20 | Sector number for the load |
| page_upd_we | output | 1 | Write strobe for the page start address |
| page_upd_data | output | 16 | New page start address |
| id_we | output | 1 | Strobe to write identity bytes into boot RAM |
| id_byte0 | output | 8 | Value for boot RAM word 0 |
| id_byte1 | output | 8 | Value for boot RAM word 1 |
| id_byte2 | output | 8 | Value for boot RAM word 2 |

## Verification
The only hidden state is the armed flag. If it is wrong, the fault shows at the port on the very next window write. A lost arm drops a load pulse that should have come. A stuck arm swallows a reset or identity command, or turns a later 0x0000 write into a load that was never armed. The bench therefore follows each arm write with a second write that is either a zero, a non-zero value, or a write outside the window. A fault in the sector or page arithmetic shows in the same cycle as load_req, so page values near the 8-bit wrap and block addresses with the top bit set and clear are applied.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam logic [15:0] CODE_WARM_RST = 16'h00F0;
  localparam logic [15:0] CODE_LOAD_ARM = 16'h00E0;
  localparam logic [15:0] CODE_READ_ID  = 16'h0090;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RST  = 2'd1,
    KIND_ARM  = 2'd2,
    KIND_ID   = 2'd3
  } cmd_kind_e;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign arst_n = sync_q[STAGES-1];
endmodule

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
  import boot_seq_pkg::*;
(
  input  logic [15:0] wr_data,
  output cmd_kind_e   kind,
  output logic        is_zero
);
  always_comb begin
    unique case (wr_data)
      CODE_WARM_RST: kind = KIND_RST;
      CODE_LOAD_ARM: kind = KIND_ARM;
      CODE_READ_ID:  kind = KIND_ID;
      default:       kind = KIND_NONE;
    endcase
  end

  assign is_zero = (wr_data == 16'h0000);
endmodule

// File: rtl/boot_sector_calc.sv
module boot_sector_calc #(
  parameter int          BLK_W        = 12,
  parameter int          PPB_W        = 6,
  parameter int          SPP_W        = 2,
  parameter logic [11:0] DENSITY_MASK = 12'h200,
  localparam int         PG_W         = PPB_W + SPP_W,
  localparam int         SEC_W        = BLK_W + PG_W
) (
  input  logic [15:0]      blk_addr,
  input  logic [15:0]      page_addr,
  output logic [SEC_W-1:0] sector,
  output logic [15:0]      page_next
);
  localparam logic [PG_W-1:0] PAGE_STEP = PG_W'(1 << SPP_W);

  logic [BLK_W-1:0] blk_field;
  logic [PG_W-1:0]  page_field;

  // Top address bit selects the upper-die density merge
  assign blk_field  = blk_addr[BLK_W-1:0] |
                      (blk_addr[15] ? BLK_W'(DENSITY_MASK) : '0);
  assign page_field = page_addr[PG_W-1:0];

  // Block field above page-in-block above sector-in-page
  assign sector     = {blk_field, page_field};
  assign page_next  = {{(16-PG_W){1'b0}}, page_field + PAGE_STEP};
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter int          BLK_W        = 12,
  parameter int          PPB_W        = 6,
  parameter int          SPP_W        = 2,
  parameter logic [11:0] DENSITY_MASK = 12'h200,
  parameter int          SYNC_STAGES  = 2,
  localparam int         SEC_W        = BLK_W + PPB_W + SPP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             win_hit,
  input  logic [15:0]      wr_data,
  input  logic [15:0]      blk_addr,
  input  logic [15:0]      page_addr,
  input  logic [15:0]      mfr_id,
  input  logic [15:0]      dev_id,
  input  logic [15:0]      prot_stat,
  output logic             rst_req,
  output logic             load_req,
  output logic [SEC_W-1:0] load_sector,
  output logic             page_upd_we,
  output logic [15:0]      page_upd_data,
  output logic             id_we,
  output logic [7:0]       id_byte0,
  output logic [7:0]       id_byte1,
  output logic [7:0]       id_byte2
);
  logic             arst_n;
  cmd_kind_e        kind;
  logic             is_zero;
  logic [SEC_W-1:0] sec_calc;
  logic [15:0]      page_calc;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .arst_n(arst_n)
  );

  boot_cmd_decode u_dec (
    .wr_data(wr_data), .kind(kind), .is_zero(is_zero)
  );

  boot_sector_calc #(
    .BLK_W(BLK_W), .PPB_W(PPB_W), .SPP_W(SPP_W), .DENSITY_MASK(DENSITY_MASK)
  ) u_calc (
    .blk_addr(blk_addr), .page_addr(page_addr),
    .sector(sec_calc), .page_next(page_calc)
  );

  // State and output registers
  logic             armed_q, armed_d;
  logic             rst_q, rst_d;
  logic             load_q, load_d;
  logic             id_q, id_d;
  logic [SEC_W-1:0] sec_q;
  logic [15:0]      pg_q;
  logic [7:0]       b0_q, b1_q, b2_q;

  logic hit;
  assign hit = wr_en && win_hit;

  // Next-state logic
  always_comb begin
    armed_d = armed_q;
    rst_d   = 1'b0;
    load_d  = 1'b0;
    id_d    = 1'b0;
    if (hit) begin
      if (armed_q) begin
        armed_d = 1'b0;
        load_d  = is_zero;
      end else begin
        unique case (kind)
          KIND_RST: rst_d   = 1'b1;
          KIND_ARM: armed_d = 1'b1;
          KIND_ID:  id_d    = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      load_q  <= 1'b0;
      id_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      rst_q   <= rst_d;
      load_q  <= load_d;
      id_q    <= id_d;
    end
  end

  // Payload registers, enabled only by their own strobe
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sec_q <= '0;
      pg_q  <= '0;
    end else if (load_d) begin
      sec_q <= sec_calc;
      pg_q  <= page_calc;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      b0_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
    end else if (id_d) begin
      b0_q <= mfr_id[7:0];
      b1_q <= dev_id[7:0];
      b2_q <= prot_stat[7:0];
    end
  end

  assign rst_req       = rst_q;
  assign load_req      = load_q;
  assign load_sector   = sec_q;
  assign page_upd_we   = load_q;
  assign page_upd_data = pg_q;
  assign id_we         = id_q;
  assign id_byte0      = b0_q;
  assign id_byte1      = b1_q;
  assign id_byte2      = b2_q;

  // Strobes never overlap (R2, R4, R7)
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({rst_req, load_req, id_we}));

  // A load fires only after a zero-data window write (R4)
  a_r4_load_after_zero: assert property (@(posedge clk) disable iff (!arst_n)
    load_req |-> $past(wr_en && win_hit && wr_data == 16'h0000));

  // Page advance is one page modulo the low byte (R5)
  a_r5_page_step: assert property (@(posedge clk) disable iff (!arst_n)
    page_upd_we |-> page_upd_data == {8'h00, $past(page_addr[7:0]) + 8'd4});

  // Load disarms the sequencer (R4)
  a_r4_disarm: assert property (@(posedge clk) disable iff (!arst_n)
    load_req |-> !armed_q);

  // Identity bytes track the inputs at the command write (R7)
  a_r7_id_bytes: assert property (@(posedge clk) disable iff (!arst_n)
    id_we |-> (id_byte0 == $past(mfr_id[7:0]) && id_byte2 == $past(prot_stat[7:0])));

  // Reset request follows an unarmed reset code (R2)
  a_r2_reset_code: assert property (@(posedge clk) disable iff (!arst_n)
    rst_req |-> $past(wr_data == 16'h00F0 && wr_en && win_hit));

endmodule

// File: tb/sim_boot_cmd_seq.sv
module sim_boot_cmd_seq;
  localparam logic [11:0] DM = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, win_hit;
  logic [15:0] wr_data, blk_addr, page_addr, mfr_id, dev_id, prot_stat;
  logic        rst_req, load_req, page_upd_we, id_we;
  logic [19:0] load_sector;
  logic [15:0] page_upd_data;
  logic [7:0]  id_byte0, id_byte1, id_byte2;

  always #10 clk = ~clk;

  boot_cmd_seq #(.DENSITY_MASK(DM)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_hit(win_hit),
    .wr_data(wr_data), .blk_addr(blk_addr), .page_addr(page_addr),
    .mfr_id(mfr_id), .dev_id(dev_id), .prot_stat(prot_stat),
    .rst_req(rst_req), .load_req(load_req), .load_sector(load_sector),
    .page_upd_we(page_upd_we), .page_upd_data(page_upd_data),
    .id_we(id_we), .id_byte0(id_byte0), .id_byte1(id_byte1), .id_byte2(id_byte2)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit armed = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare at the next falling edge
  task automatic step(input string tag, input bit we, input bit hit,
                      input logic [15:0] d, input logic [15:0] blk,
                      input logic [15:0] pg);
    bit e_rst, e_load, e_id;
    logic [19:0] e_sec;
    logic [15:0] e_pg;
    logic [11:0] bf;
    e_rst = 0; e_load = 0; e_id = 0;
    wr_en = we; win_hit = hit; wr_data = d; blk_addr = blk; page_addr = pg;
    bf = blk[11:0] | (blk[15] ? DM : 12'h000);
    e_sec = {bf, pg[7:0]};
    e_pg  = {8'h00, 8'(pg[7:0] + 8'd4)};
    if (we && hit) begin
      if (armed) begin
        armed = 0;
        e_load = (d == 16'h0000);
      end else if (d == 16'h00F0) e_rst = 1;
      else if (d == 16'h00E0) armed = 1;
      else if (d == 16'h0090) e_id = 1;
    end
    @(negedge clk);
    wr_en = 0;
    chk(tag, "rst_req", 32'(rst_req), 32'(e_rst));
    chk(tag, "load_req", 32'(load_req), 32'(e_load));
    chk(tag, "page_upd_we", 32'(page_upd_we), 32'(e_load));
    chk(tag, "id_we", 32'(id_we), 32'(e_id));
    if (e_load) begin
      chk(tag, "load_sector", 32'(load_sector), 32'(e_sec));
      chk(tag, "page_upd_data", 32'(page_upd_data), 32'(e_pg));
    end
    if (e_id) begin
      chk(tag, "id_byte0", 32'(id_byte0), 32'(mfr_id[7:0]));
      chk(tag, "id_byte1", 32'(id_byte1), 32'(dev_id[7:0]));
      chk(tag, "id_byte2", 32'(id_byte2), 32'(prot_stat[7:0]));
    end
  endtask

  initial begin
    rst_n = 0; wr_en = 0; win_hit = 0; wr_data = 0;
    blk_addr = 0; page_addr = 0;
    mfr_id = 16'h12AB; dev_id = 16'h34CD; prot_stat = 16'h0002;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "strobes in reset", 32'({rst_req, load_req, page_upd_we, id_we}), 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1", 0, 0, 16'h0, 16'h0, 16'h0);

    // R7: identification bytes
    step("R7", 1, 1, 16'h0090, 16'h0, 16'h0);
    // R2: warm reset request
    step("R2", 1, 1, 16'h00F0, 16'h0, 16'h0);
    // R3 then R4/R5: arm then fire
    step("R3", 1, 1, 16'h00E0, 16'h0005, 16'h0010);
    step("R4", 1, 1, 16'h0000, 16'h0005, 16'h0010);
    // R5: page wrap, upper page bits dropped
    step("R3", 1, 1, 16'h00E0, 16'h0001, 16'hABFC);
    step("R5", 1, 1, 16'h0000, 16'h0001, 16'hABFC);
    // R9: top block bit merges the density mask
    step("R3", 1, 1, 16'h00E0, 16'h8043, 16'h00FD);
    step("R9", 1, 1, 16'h0000, 16'h8043, 16'h00FD);
    step("R3", 1, 1, 16'h00E0, 16'h0043, 16'h0001);
    step("R9", 1, 1, 16'h0000, 16'h0043, 16'h0001);
    // R6: non-zero second cycle disarms and is consumed
    step("R3", 1, 1, 16'h00E0, 16'h0, 16'h0);
    step("R6", 1, 1, 16'h00F0, 16'h0, 16'h0);
    step("R6", 1, 1, 16'h0000, 16'h0, 16'h0);
    step("R3", 1, 1, 16'h00E0, 16'h0, 16'h0);
    step("R6", 1, 1, 16'h0090, 16'h0, 16'h0);
    step("R6", 1, 1, 16'h0000, 16'h0, 16'h0);
    // R8: off-window and unstrobed writes leave the arm in place
    step("R3", 1, 1, 16'h00E0, 16'h0007, 16'h0020);
    step("R8", 1, 0, 16'h00F0, 16'h0007, 16'h0020);
    step("R8", 0, 1, 16'h1234, 16'h0007, 16'h0020);
    step("R8", 1, 1, 16'h0000, 16'h0007, 16'h0020);
    // R8: unknown values ignored
    step("R8", 1, 1, 16'h5555, 16'h0, 16'h0);
    step("R8", 1, 1, 16'h0000, 16'h0, 16'h0);
    step("R8", 1, 1, 16'h01F0, 16'h0, 16'h0);

    // Mixed traffic against the model
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        logic [15:0] d;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (lf[2:0])
          3'd0, 3'd1: d = 16'h0000;
          3'd2, 3'd3: d = 16'h00E0;
          3'd4:       d = 16'h00F0;
          3'd5:       d = 16'h0090;
          default:    d = lf;
        endcase
        mfr_id = {lf[7:0], lf[15:8]};
        step("R4", lf[3] | lf[4], lf[5] | lf[6], d, {lf[15], 3'b0, lf[11:0]}, lf ^ 16'h5A5A);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule